// File: doc/BRIEF.md
# Warp Instruction Issue Scheduler

This block chooses, every clock, at most one instruction to send to the execution units from a fixed group of resident warps. Each warp offers its next instruction as a valid flag, a destination register, two source registers and a unit class. An instruction may leave only when three conditions hold. First, none of its registers is still waiting on an earlier write from the same warp. Second, the unit class it targets has finished the previous warp instruction. Third, it is the first eligible warp in round-robin order.

A warp instruction covers 32 threads, but each unit class has fewer physical lanes than that. A class therefore stays occupied for the warp width divided by its lane count. A per-warp scoreboard enforces a short fixed latency between a producer and any instruction that reads or rewrites its destination. The issue strobe is combinational from the presented instructions and the stored state. The front end treats a strobe naming its warp as acceptance and offers that warp's next instruction in the following cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high the issue strobe is low. In the first cycle after reset, with an instruction presented only by warp 0, warp 0 issues in that same cycle.
- R2: At most one instruction issues per cycle. `issueValid` is high in the cycle an eligible instruction is presented, `issueWarp` names the warp and `issueUnit` gives its class, encoded 0 single precision, 1 integer, 2 double precision, 3 special function.
- R3: An instruction whose source register matches the destination of an earlier instruction from the same warp issues no earlier than DEP_LATENCY (default 4) cycles after that producer issued.
- R4: Scoreboard state is kept per warp. A pending register in one warp never delays an instruction of another warp that uses the same register number.
- R5: Independent instructions of one warp aimed at free unit classes issue on consecutive cycles.
- R6: The single-precision and integer classes have 16 lanes each. After an issue to either class, the next issue to that same class comes no earlier than 2 cycles later.
- R7: The double-precision class has 8 lanes. After an issue to it, the next issue to that class comes no earlier than 4 cycles later.
- R8: The special-function class has 1 lane. After an issue to it, the next issue to that class comes no earlier than 32 cycles later.
- R9: Among eligible warps, the winner is the first found when searching upward from the warp after the one that issued last, wrapping around. After reset the search starts at warp 0.
- R10: In a cycle with no eligible warp the strobe stays low and the round-robin position does not change.
- R11: An instruction whose destination is still pending in its own warp waits under the same latency rule as a source dependency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | NUM_WARPS | Per-warp flag: an instruction is presented |
| instDst | input | NUM_WARPS*REG_W | Per-warp destination register index, warp w in bits [w*REG_W +: REG_W] |
| instSrcA | input | NUM_WARPS*REG_W | Per-warp first source register index |
| instSrcB | input | NUM_WARPS*REG_W | Per-warp second source register index |
| instUnit | input | 2*NUM_WARPS | Per-warp unit class, warp w in bits [2w +: 2] |
| issueValid | output | 1 | An instruction issues this cycle |
| issueWarp | output | WID_W | Warp id of the issued instruction |
| issueUnit | output | 2 | Unit class of the issued instruction |

## Verification
The bench builds the block with its defaults: four warps, eight registers per warp, a dependent latency of four, and lane counts of 16, 16, 8 and 1 for a 32-thread warp. Four warps are enough for the round-robin search to wrap and revisit warp 0. With only one lane, the special-function class exposes the full 32-cycle occupancy window. The four-cycle scoreboard window is short enough that every stalled cycle before release can be checked individually.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Upper bound on warp id width carried in the control strobe struct
  localparam int MAX_WARP_ID_W = 4;
  localparam int NUM_CLASSES   = 4;

  typedef enum logic [1:0] {
    UC_SP  = 2'd0,
    UC_INT = 2'd1,
    UC_DP  = 2'd2,
    UC_SFU = 2'd3
  } unitClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                     fire;
    logic [MAX_WARP_ID_W-1:0] warp;
  } issueCtl_t;

  // Cycles a class is held by one warp instruction
  function automatic int occCycles(input int warpSize, input int lanes);
    return (warpSize + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/warp_sched_dp.sv
module warp_sched_dp
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS   = 4,
  parameter int NUM_REGS    = 8,
  parameter int DEP_LATENCY = 4,
  parameter int WARP_SIZE   = 32,
  parameter int SP_LANES    = 16,
  parameter int INT_LANES   = 16,
  parameter int DP_LANES    = 8,
  parameter int SFU_LANES   = 1,
  localparam int REG_W      = $clog2(NUM_REGS),
  localparam int WID_W      = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       instValid,
  input  logic [NUM_WARPS*REG_W-1:0] instDst,
  input  logic [NUM_WARPS*REG_W-1:0] instSrcA,
  input  logic [NUM_WARPS*REG_W-1:0] instSrcB,
  input  logic [NUM_WARPS*2-1:0]     instUnit,
  input  issueCtl_t                  ctl,
  output logic [NUM_WARPS-1:0]       warpReady,
  output unitClass_e                 selUnit
);

  localparam int SB_W   = $clog2(DEP_LATENCY + 1);
  localparam int BUSY_W = $clog2(WARP_SIZE + 1);

  logic [REG_W-1:0]    dstOf  [NUM_WARPS];
  logic [REG_W-1:0]    srcAOf [NUM_WARPS];
  logic [REG_W-1:0]    srcBOf [NUM_WARPS];
  unitClass_e          unitOf [NUM_WARPS];
  logic [NUM_REGS-1:0] regBusy [NUM_WARPS];
  logic [SB_W-1:0]     sbCnt  [NUM_WARPS][NUM_REGS];
  logic [BUSY_W-1:0]   unitCnt [NUM_CLASSES];
  logic [NUM_CLASSES-1:0] classBusy;
  logic [WID_W-1:0]    selWarp;

  assign selWarp = ctl.warp[WID_W-1:0];
  assign selUnit = unitOf[selWarp];

  // ---------------- per-warp field unpack, scoreboard, readiness ----------------
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign dstOf[w]  = instDst [w*REG_W +: REG_W];
    assign srcAOf[w] = instSrcA[w*REG_W +: REG_W];
    assign srcBOf[w] = instSrcB[w*REG_W +: REG_W];
    assign unitOf[w] = unitClass_e'(instUnit[w*2 +: 2]);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic loadHit;
      assign loadHit = ctl.fire && (ctl.warp == MAX_WARP_ID_W'(w))
                       && (dstOf[w] == REG_W'(r));

      always_ff @(posedge clk) begin
        if (rst)                sbCnt[w][r] <= '0;
        else if (loadHit)       sbCnt[w][r] <= SB_W'(DEP_LATENCY - 1);
        else if (sbCnt[w][r] != '0) sbCnt[w][r] <= sbCnt[w][r] - 1'b1;
      end

      assign regBusy[w][r] = (sbCnt[w][r] != '0);

      // R3: a pending entry counts down by one each cycle unless reloaded
      p_sb_countdown_r3: assert property (@(posedge clk) disable iff (rst)
        (sbCnt[w][r] != '0 && !loadHit) |=> (sbCnt[w][r] == $past(sbCnt[w][r]) - 1'b1));
    end

    assign warpReady[w] = instValid[w]
                          && !regBusy[w][srcAOf[w]]
                          && !regBusy[w][srcBOf[w]]
                          && !regBusy[w][dstOf[w]]
                          && !classBusy[unitOf[w]];
  end

  // ---------------- unit class occupancy ----------------
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    localparam int LANES = (c == 0) ? SP_LANES  :
                           (c == 1) ? INT_LANES :
                           (c == 2) ? DP_LANES  : SFU_LANES;
    localparam int OCC   = occCycles(WARP_SIZE, LANES);

    always_ff @(posedge clk) begin
      if (rst)
        unitCnt[c] <= '0;
      else if (ctl.fire && selUnit == unitClass_e'(c))
        unitCnt[c] <= BUSY_W'(OCC - 1);
      else if (unitCnt[c] != '0)
        unitCnt[c] <= unitCnt[c] - 1'b1;
    end

    assign classBusy[c] = (unitCnt[c] != '0);

    // R6 R7 R8: a class that takes an issue is held in the following cycle
    if (OCC >= 2) begin : g_hold
      p_class_held_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.fire && selUnit == unitClass_e'(c)) |=> classBusy[c]);
    end
  end

  // R3 R11: the granted warp never has a pending source or destination
  p_regs_free_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.fire |-> (!regBusy[selWarp][srcAOf[selWarp]] && !regBusy[selWarp][srcBOf[selWarp]]
                  && !regBusy[selWarp][dstOf[selWarp]]));

  // R6: no issue lands on an occupied class
  p_class_free_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.fire |-> !classBusy[selUnit]);

endmodule

// File: rtl/warp_sched_ctl.sv
module warp_sched_ctl
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warpReady,
  output issueCtl_t            ctl
);

  logic [WID_W-1:0] lastWarp;
  logic [WID_W-1:0] nextWarp;
  logic [WID_W-1:0] pick;
  logic             found;

  assign nextWarp = (lastWarp == WID_W'(NUM_WARPS - 1)) ? '0 : lastWarp + 1'b1;

  // Search upward from the warp after the last issuer, wrapping
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = (int'(lastWarp) + k) % NUM_WARPS;
      if (!found && warpReady[WID_W'(idx)]) begin
        found = 1'b1;
        pick  = WID_W'(idx);
      end
    end
  end

  assign ctl.fire = found && !rst;
  assign ctl.warp = MAX_WARP_ID_W'(pick);

  always_ff @(posedge clk) begin
    if (rst)           lastWarp <= WID_W'(NUM_WARPS - 1);
    else if (ctl.fire) lastWarp <= pick;
  end

  // R2: only a ready warp is granted
  p_grant_ready_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.fire |-> warpReady[pick]);

  // R9: the warp right after the last issuer wins whenever it is ready
  p_rr_first_r9: assert property (@(posedge clk) disable iff (rst)
    warpReady[nextWarp] |-> (ctl.fire && pick == nextWarp));

  // R10: an idle cycle leaves the round-robin position untouched
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl.fire |=> $stable(lastWarp));

  // R10: no ready warp means no strobe
  p_no_fire_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (warpReady == '0) |-> !ctl.fire);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS   = 4,
  parameter int NUM_REGS    = 8,
  parameter int DEP_LATENCY = 4,
  parameter int WARP_SIZE   = 32,
  parameter int SP_LANES    = 16,
  parameter int INT_LANES   = 16,
  parameter int DP_LANES    = 8,
  parameter int SFU_LANES   = 1,
  localparam int REG_W      = $clog2(NUM_REGS),
  localparam int WID_W      = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       instValid,
  input  logic [NUM_WARPS*REG_W-1:0] instDst,
  input  logic [NUM_WARPS*REG_W-1:0] instSrcA,
  input  logic [NUM_WARPS*REG_W-1:0] instSrcB,
  input  logic [NUM_WARPS*2-1:0]     instUnit,
  output logic                       issueValid,
  output logic [WID_W-1:0]           issueWarp,
  output logic [1:0]                 issueUnit
);

  // NUM_WARPS must lie in 2..2**MAX_WARP_ID_W, NUM_REGS at least 2
  issueCtl_t        ctl;
  logic [NUM_WARPS-1:0] warpReady;
  unitClass_e       selUnit;

  warp_sched_ctl #(.NUM_WARPS(NUM_WARPS)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .warpReady (warpReady),
    .ctl       (ctl)
  );

  warp_sched_dp #(
    .NUM_WARPS   (NUM_WARPS),
    .NUM_REGS    (NUM_REGS),
    .DEP_LATENCY (DEP_LATENCY),
    .WARP_SIZE   (WARP_SIZE),
    .SP_LANES    (SP_LANES),
    .INT_LANES   (INT_LANES),
    .DP_LANES    (DP_LANES),
    .SFU_LANES   (SFU_LANES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .instDst   (instDst),
    .instSrcA  (instSrcA),
    .instSrcB  (instSrcB),
    .instUnit  (instUnit),
    .ctl       (ctl),
    .warpReady (warpReady),
    .selUnit   (selUnit)
  );

  assign issueValid = ctl.fire;
  assign issueWarp  = ctl.warp[WID_W-1:0];
  assign issueUnit  = selUnit;

  // R1: no strobe while in reset
  p_quiet_in_reset_r1: assert property (@(posedge clk) rst |-> !issueValid);

endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;

  localparam int NW = 4;
  localparam int RW = 3;
  localparam int SP = 0, IN = 1, DP = 2, SF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]    vld;
  logic [RW-1:0]    dstA [NW];
  logic [RW-1:0]    sa   [NW];
  logic [RW-1:0]    sb   [NW];
  logic [1:0]       un   [NW];
  logic [NW*RW-1:0] instDst, instSrcA, instSrcB;
  logic [NW*2-1:0]  instUnit;
  logic             issueValid;
  logic [1:0]       issueWarp;
  logic [1:0]       issueUnit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      instDst [w*RW +: RW] = dstA[w];
      instSrcA[w*RW +: RW] = sa[w];
      instSrcB[w*RW +: RW] = sb[w];
      instUnit[w*2 +: 2]   = un[w];
    end
  end

  warp_issue_sched u0 (
    .clk(clk), .rst(rst), .instValid(vld), .instDst(instDst), .instSrcA(instSrcA),
    .instSrcB(instSrcB), .instUnit(instUnit), .issueValid(issueValid),
    .issueWarp(issueWarp), .issueUnit(issueUnit)
  );

  task automatic put(input int w, input int u, input int d, input int a, input int b);
    vld[w] = 1'b1; un[w] = 2'(u); dstA[w] = RW'(d); sa[w] = RW'(a); sb[w] = RW'(b);
  endtask

  task automatic drop(input int w);
    vld[w] = 1'b0;
  endtask

  task automatic dropAll();
    for (int w = 0; w < NW; w++) begin
      vld[w] = 1'b0; un[w] = '0; dstA[w] = '0; sa[w] = '0; sb[w] = '0;
    end
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  task automatic look(input string req, input bit ev, input int ew, input int eu);
    #1;
    nChecks++;
    if (issueValid !== ev || (ev && (int'(issueWarp) != ew || int'(issueUnit) != eu))) begin
      nFails++;
      $display("FAIL %s: got v=%0b w=%0d u=%0d, expected v=%0b w=%0d u=%0d",
               req, issueValid, issueWarp, issueUnit, ev, ew, eu);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    dropAll();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: quiet during reset, warp 0 issues in the first cycle after
  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    dropAll();
    put(0, SP, 1, 2, 3);
    look("R1 in reset", 1'b0, 0, 0);
    repeat (2) @(negedge clk);
    look("R1 still in reset", 1'b0, 0, 0);
    rst = 1'b0;
    look("R1 first cycle after reset", 1'b1, 0, SP);
    nextCycle(); dropAll();
    look("R1 idle after consume", 1'b0, 0, 0);
  endtask

  // R3: source dependency waits DEP_LATENCY cycles
  task automatic testRaw();
    doReset();
    put(0, SP, 5, 1, 2);
    look("R3 producer", 1'b1, 0, SP);
    nextCycle(); put(0, IN, 6, 5, 1);
    look("R3 stall +1", 1'b0, 0, 0);
    nextCycle(); look("R3 stall +2", 1'b0, 0, 0);
    nextCycle(); look("R3 stall +3", 1'b0, 0, 0);
    nextCycle(); look("R3 release +4", 1'b1, 0, IN);
    nextCycle(); dropAll();
  endtask

  // R4: scoreboard is per warp
  task automatic testPerWarp();
    doReset();
    put(0, SP, 5, 1, 2);
    look("R4 producer w0", 1'b1, 0, SP);
    nextCycle(); put(0, IN, 6, 1, 5); put(1, IN, 7, 5, 5);
    look("R4 other warp same reg", 1'b1, 1, IN);
    nextCycle(); drop(1);
    look("R4 w0 still blocked +2", 1'b0, 0, 0);
    nextCycle(); look("R3 srcB blocked +3", 1'b0, 0, 0);
    nextCycle(); look("R3 srcB release +4", 1'b1, 0, IN);
    nextCycle(); dropAll();
  endtask

  // R5: independent instructions of one warp back to back
  task automatic testConsecutive();
    doReset();
    put(0, IN, 1, 2, 3);
    look("R5 cycle 0 INT", 1'b1, 0, IN);
    nextCycle(); put(0, SP, 4, 5, 6);
    look("R5 cycle 1 SP", 1'b1, 0, SP);
    nextCycle(); put(0, DP, 7, 2, 3);
    look("R5 cycle 2 DP", 1'b1, 0, DP);
    nextCycle(); put(0, SF, 0, 5, 6);
    look("R5 cycle 3 SFU", 1'b1, 0, SF);
    nextCycle(); dropAll();
  endtask

  // R6: SP and INT held two cycles
  task automatic testSpInt();
    doReset();
    put(0, SP, 1, 2, 3);
    look("R6 SP first", 1'b1, 0, SP);
    nextCycle(); drop(0); put(1, SP, 2, 3, 4);
    look("R6 SP busy", 1'b0, 0, 0);
    nextCycle(); look("R6 SP free +2", 1'b1, 1, SP);
    nextCycle(); drop(1); put(0, IN, 3, 4, 5);
    look("R6 INT first", 1'b1, 0, IN);
    nextCycle(); drop(0); put(1, IN, 4, 5, 6);
    look("R6 INT busy", 1'b0, 0, 0);
    nextCycle(); look("R6 INT free +2", 1'b1, 1, IN);
    nextCycle(); dropAll();
  endtask

  // R7: DP held four cycles
  task automatic testDp();
    doReset();
    put(0, DP, 1, 2, 3);
    look("R7 DP first", 1'b1, 0, DP);
    nextCycle(); drop(0); put(1, DP, 2, 3, 4);
    look("R7 DP busy +1", 1'b0, 0, 0);
    nextCycle(); look("R7 DP busy +2", 1'b0, 0, 0);
    nextCycle(); look("R7 DP busy +3", 1'b0, 0, 0);
    nextCycle(); look("R7 DP free +4", 1'b1, 1, DP);
    nextCycle(); dropAll();
  endtask

  // R8: SFU held thirty-two cycles
  task automatic testSfu();
    doReset();
    put(0, SF, 1, 2, 3);
    look("R8 SFU first", 1'b1, 0, SF);
    nextCycle(); drop(0); put(1, SF, 2, 3, 4);
    look("R8 SFU busy +1", 1'b0, 0, 0);
    for (int c = 2; c < 32; c++) begin
      nextCycle(); look("R8 SFU busy", 1'b0, 0, 0);
    end
    nextCycle(); look("R8 SFU free +32", 1'b1, 1, SF);
    nextCycle(); dropAll();
  endtask

  // R9: round-robin order with wrap
  task automatic testRoundRobin();
    doReset();
    for (int w = 0; w < NW; w++) put(w, SP, 1, 2, 3);
    for (int c = 0; c <= 8; c++) begin
      if (c > 0) nextCycle();
      if (c % 2 == 0) look("R9 rotation", 1'b1, (c / 2) % NW, SP);
      else            look("R10 SP busy gap", 1'b0, 0, 0);
    end
    nextCycle(); dropAll();
  endtask

  // R10: idle cycle keeps pointer in place
  task automatic testIdleHold();
    doReset();
    put(2, IN, 1, 2, 3);
    look("R10 w2 issues", 1'b1, 2, IN);
    nextCycle(); dropAll();
    look("R10 idle cycle", 1'b0, 0, 0);
    nextCycle(); put(0, SP, 1, 2, 3); put(3, SP, 1, 2, 3);
    look("R10 pointer held picks w3", 1'b1, 3, SP);
    nextCycle(); dropAll();
  endtask

  // R11: destination still pending waits too
  task automatic testWaw();
    doReset();
    put(0, SP, 4, 1, 2);
    look("R11 first write", 1'b1, 0, SP);
    nextCycle(); put(0, IN, 4, 1, 2);
    look("R11 stall +1", 1'b0, 0, 0);
    nextCycle(); look("R11 stall +2", 1'b0, 0, 0);
    nextCycle(); look("R11 stall +3", 1'b0, 0, 0);
    nextCycle(); look("R11 release +4", 1'b1, 0, IN);
    nextCycle(); dropAll();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    dropAll();
    testReset();
    testRaw();
    testPerWarp();
    testConsecutive();
    testSpInt();
    testDp();
    testSfu();
    testRoundRobin();
    testIdleHold();
    testWaw();
    finish();
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish();
  end

endmodule